// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block sets the pace of an I2C master's serial clock from the peripheral clock. A 32-bit divider word carries two independent counts: one sizes the low half of each SCL period and the other sizes the high half. Each half lasts eight peripheral clocks for every unit of its count plus one. The duty cycle can therefore be uneven, with the high half one unit longer than the low half, as a rounded divisor split requires.

The bit engine raises `run` for as long as a transfer is in progress. While `run` is high, the timer cycles through a low phase and then a high phase. It requests the SCL level on `scl_req` and gives two single-cycle strobes. `chg_stb` marks the middle of each low phase, where SDA may change. `smp_stb` marks the middle of each high phase, where SDA is sampled. The divider word is captured only at the start of each low phase. A change made mid-period therefore never cuts a phase short.

The controller has three states. `ST_IDLE` holds SCL high with the counter at zero. `ST_LOW` drives SCL low. `ST_HIGH` releases SCL. The transitions are as follows. `IDLE→LOW` happens when `run` is seen high, and it captures the divider. `LOW→HIGH` happens at the last count of the low phase. `HIGH→LOW` happens at the last count of the high phase, and it captures the divider again. `LOW→IDLE` and `HIGH→IDLE` happen whenever `run` is seen low.

Top module: `sclgen_div`

## Requirements
- R1: After reset and while `run` is low, `scl_req` is 1 and both strobes are 0.
- R2: The low-phase count is taken from `div_cfg[15:0]` and the high-phase count from `div_cfg[31:16]`. A low phase holds `scl_req`=0 for 8×(low+1) cycles. A high phase holds `scl_req`=1 for 8×(high+1) cycles.
- R3: One full SCL period spans 8×((low+1)+(high+1)) cycles, so a divider word of zero gives a 16-cycle period.
- R4: In every low phase, `chg_stb` pulses exactly once, for one cycle, 4×(low+1) cycles after the phase begins (counting from 0). It never pulses while `scl_req` is 1.
- R5: In every high phase, `smp_stb` pulses exactly once, for one cycle, 4×(high+1) cycles after the phase begins. It never pulses while `scl_req` is 0.
- R6: The divider word is sampled only when a low phase starts. Both the low phase and the high phase that follows it use that sample, whatever `div_cfg` does meanwhile.
- R7: When `run` is seen low, the next cycle shows `scl_req`=1 with no strobes and a cleared count. A later restart begins with a full-length low phase.
- R8: The first phase after `run` is seen high is a low phase, visible one cycle after that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables SCL generation; low forces idle |
| div_cfg | input | 32 | Divider word: low count [15:0], high count [31:16] |
| scl_req | output | 1 | Requested SCL level (0 = drive low) |
| chg_stb | output | 1 | One-cycle pulse at mid low phase (SDA change point) |
| smp_stb | output | 1 | One-cycle pulse at mid high phase (SDA sample point) |

## Verification
The assertions check the following on every cycle. Each strobe belongs to its own SCL level. The count never passes its phase limit. The captured divider holds still through every low phase. The timer falls to idle one cycle after `run` drops, and the first phase after a start is always low. Only the bench scenarios can show the exact lengths of the phases, the exact strobe offsets and the periods that follow from particular divider words, including the zero word and uneven splits. The same holds for the rule that a mid-period divider change takes effect only at the next low phase. The bench checks these lengths and offsets against its own arithmetic.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

    localparam int unsigned N_FIELDS = 2;
    localparam int unsigned FLD_LO   = 0;
    localparam int unsigned FLD_HI   = 1;

endpackage

// File: rtl/sclgen_shadow.sv
module sclgen_shadow #(
    parameter int unsigned FIELD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [2*FIELD_W-1:0]      cfg,
    output logic [FIELD_W-1:0]        lo_q,
    output logic [FIELD_W-1:0]        hi_q
);
    import sclgen_pkg::*;

    logic [N_FIELDS-1:0][FIELD_W-1:0] fld_q;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld_q[g] <= '0;
            end else if (load) begin
                fld_q[g] <= cfg[g*FIELD_W +: FIELD_W];
            end
        end
    end

    assign lo_q = fld_q[FLD_LO];
    assign hi_q = fld_q[FLD_HI];

endmodule

// File: rtl/sclgen_tick.sv
module sclgen_tick #(
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim,
    input  logic [CNT_W-1:0] mid,
    output logic             at_end,
    output logic             at_mid
);
    logic [CNT_W-1:0] cnt_q;

    assign at_end = (cnt_q == lim);
    assign at_mid = (cnt_q == mid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count stays inside the current phase limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

endmodule

// File: rtl/sclgen_div.sv
module sclgen_div #(
    parameter int unsigned FIELD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [2*FIELD_W-1:0] div_cfg,
    output logic                 scl_req,
    output logic                 chg_stb,
    output logic                 smp_stb
);
    import sclgen_pkg::*;

    localparam int unsigned CNT_W = FIELD_W + 3;

    scl_state_e         st_q, st_d;
    logic [FIELD_W-1:0] shd_lo, shd_hi, sel_fld;
    logic [CNT_W-1:0]   lim, mid;
    logic               at_end, at_mid, load_shd, clr_cnt;

    // capture the divider at every low-phase start
    assign load_shd = run && ((st_q == ST_IDLE) || ((st_q == ST_HIGH) && at_end));
    assign clr_cnt  = (st_q == ST_IDLE) || !run;

    sclgen_shadow #(.FIELD_W(FIELD_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_shd),
        .cfg   (div_cfg),
        .lo_q  (shd_lo),
        .hi_q  (shd_hi)
    );

    // phase length 8*(n+1) -> last index 8n+7; midpoint 4*(n+1)
    assign sel_fld = (st_q == ST_HIGH) ? shd_hi : shd_lo;
    assign lim     = {sel_fld, 3'b111};
    assign mid     = {({1'b0, sel_fld} + 1'b1), 2'b00};

    sclgen_tick #(.CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_cnt),
        .lim    (lim),
        .mid    (mid),
        .at_end (at_end),
        .at_mid (at_mid)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (run) st_d = ST_LOW;
            ST_LOW: begin
                if (!run)        st_d = ST_IDLE;
                else if (at_end) st_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!run)        st_d = ST_IDLE;
                else if (at_end) st_d = ST_LOW;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        scl_req = 1'b1;
        chg_stb = 1'b0;
        smp_stb = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_LOW: begin
                scl_req = 1'b0;
                chg_stb = at_mid;
            end
            ST_HIGH: smp_stb = at_mid;
            default: ;
        endcase
    end

    // R1 / R7: idle one cycle after run is seen low
    a_r7_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_req && !chg_stb && !smp_stb));

    // R4: change strobe only while SCL is requested low
    a_r4_chg_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stb |-> !scl_req);

    // R5: sample strobe only while SCL is released
    a_r5_smp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> scl_req);

    // R6: captured divider holds through a low phase
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW) |=> $stable({shd_hi, shd_lo}));

    // R8: a start always opens with a low phase
    a_r8_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && run) |=> !scl_req);

endmodule

// File: tb/sim_sclgen_div.sv
`timescale 1ns/1ps
module sim_sclgen_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] div_cfg = '0;
    logic        scl_req, chg_stb, smp_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sclgen_div #(.FIELD_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .div_cfg(div_cfg),
        .scl_req(scl_req), .chg_stb(chg_stb), .smp_stb(smp_stb)
    );

    function automatic int exp_len(input int f); return 8 * (f + 1); endfunction
    function automatic int exp_mid(input int f); return 4 * (f + 1); endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // measure one phase at level lvl; positioned at a negedge sample
    task automatic phase(input logic lvl, input int swap_at, input logic [31:0] swap_val,
                         output int len, output int pos, output int nstb, output int nbad);
        len = 0; pos = -1; nstb = 0; nbad = 0;
        while (scl_req === lvl && len < 600000) begin
            if (len == swap_at) div_cfg = swap_val;
            if (lvl ? smp_stb : chg_stb) begin nstb++; pos = len; end
            if (lvl ? chg_stb : smp_stb) nbad++;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic check_low(input int lo, input int swap_at, input logic [31:0] swap_val);
        int l, p, n, b;
        phase(1'b0, swap_at, swap_val, l, p, n, b);
        chk(l == exp_len(lo), "R2 low length", l, exp_len(lo));
        chk(n == 1, "R4 chg count", n, 1);
        chk(p == exp_mid(lo), "R4 chg offset", p, exp_mid(lo));
        chk(b == 0, "R5 smp in low", b, 0);
    endtask

    task automatic check_high(input int hi, input int swap_at, input logic [31:0] swap_val);
        int l, p, n, b;
        phase(1'b1, swap_at, swap_val, l, p, n, b);
        chk(l == exp_len(hi), "R2 high length", l, exp_len(hi));
        chk(n == 1, "R5 smp count", n, 1);
        chk(p == exp_mid(hi), "R5 smp offset", p, exp_mid(hi));
        chk(b == 0, "R4 chg in high", b, 0);
    endtask

    task automatic start_cfg(input int lo, input int hi);
        div_cfg = {hi[15:0], lo[15:0]};
        run = 1'b1;
        @(negedge clk);
        chk(scl_req == 1'b0, "R8 first phase low", scl_req, 0);
    endtask

    task automatic run_periods(input int lo, input int hi, input int np);
        for (int k = 0; k < np; k++) begin
            int l, p, n, b, h;
            phase(1'b0, -1, '0, l, p, n, b);
            chk(l == exp_len(lo) && n == 1 && p == exp_mid(lo), "R2 low phase", l, exp_len(lo));
            chk(b == 0, "R4 no smp in low", b, 0);
            phase(1'b1, -1, '0, h, p, n, b);
            chk(h == exp_len(hi) && n == 1 && p == exp_mid(hi), "R5 high phase", h, exp_len(hi));
            chk(l + h == 8 * (lo + 1 + hi + 1), "R3 period", l + h, 8 * (lo + 1 + hi + 1));
        end
    endtask

    task automatic stop_run();
        run = 1'b0;
        @(negedge clk);
        chk(scl_req == 1'b1 && !chg_stb && !smp_stb, "R7 idle after stop", scl_req, 1);
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk(scl_req == 1'b1, "R1 reset level", scl_req, 1);
        chk(!chg_stb && !smp_stb, "R1 reset strobes", chg_stb + smp_stb, 0);
        rst_n = 1'b1;
        div_cfg = 32'h0003_0005;
        repeat (6) begin
            @(negedge clk);
            chk(scl_req == 1'b1 && !chg_stb && !smp_stb, "R1 idle while run low", scl_req, 1);
        end

        // R2: distinct fields expose their positions
        start_cfg(3, 9);
        run_periods(3, 9, 2);
        stop_run();

        // R3: zero word -> 16-cycle period
        start_cfg(0, 0);
        run_periods(0, 0, 3);
        stop_run();

        // uneven split, high one longer
        start_cfg(2, 3);
        run_periods(2, 3, 2);
        stop_run();

        // upper field bits
        start_cfg(100, 256);
        run_periods(100, 256, 1);
        stop_run();

        // R6: change during low affects the next low only
        start_cfg(4, 1);
        check_low(4, 5, {16'd6, 16'd2});
        check_high(1, -1, '0);
        check_low(2, -1, '0);
        check_high(6, -1, '0);
        stop_run();

        // R6: change during high applies at the next low
        start_cfg(1, 1);
        check_low(1, -1, '0);
        check_high(1, 3, {16'd0, 16'd5});
        check_low(5, -1, '0);
        check_high(0, -1, '0);
        stop_run();

        // R7: stop in mid phase, then restart with a full low phase
        start_cfg(5, 5);
        repeat (10) @(negedge clk);
        run = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk(scl_req == 1'b1 && !chg_stb && !smp_stb, "R7 held idle", scl_req, 1);
        end
        start_cfg(5, 5);
        check_low(5, -1, '0);
        check_high(5, -1, '0);
        stop_run();

        // random configurations
        for (int i = 0; i < 16; i++) begin
            int lo, hi;
            lo = int'($urandom % 16);
            hi = int'($urandom % 16);
            start_cfg(lo, hi);
            run_periods(lo, hi, 2);
            stop_run();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule